// File: doc/BRIEF.md
# Dual-Channel Register Bus Decoder

This block is the host-facing front end of a two-channel serial controller. A host reaches it over a parallel byte bus that has an active-low select, a channel-select line, a three-bit register index and separate active-low read and write strobes. Each access is routed to one of two banks of eight byte-wide registers, one bank per channel. The registers only store data and give it back. The serial engines that will later consume these values sit elsewhere.

The strobes arrive asynchronously and pass through synchronizers into the block clock. A write commits when the block detects the trailing (rising) edge of the write strobe. The host must therefore keep select, channel, index and data stable for at least four clock cycles after it raises the write strobe. A read is combinational: while select and the read strobe are both low, the addressed byte appears on `data_out` and `data_oe` is raised.

One register in each bank, the mode register at index 6, holds a broadcast flag in bit 0. While bit 0 of either bank's mode register is set, every write lands at the same index in both banks, whatever the channel-select line says. This saves the host a second pass when it sets up both channels. Reads still follow the channel-select line.

Top module: `dual_chan_regif`

## Requirements
- R1: After synchronous reset, all sixteen registers read 0 and broadcast is off.
- R2: While `cs_n` is high, a write strobe changes no register and `data_oe` stays low.
- R3: With broadcast off, a write with `ch_sel`=1 goes only to channel A and a write with `ch_sel`=0 goes only to channel B.
- R4: `addr` selects one of eight registers in the target bank. The other seven registers keep their values.
- R5: A write commits on the third rising clock edge after `wr_n` rises (two synchronizer stages plus one edge-detect stage). Before that edge, the register still reads its old value.
- R6: While `cs_n` and `rd_n` are low, `data_out` shows the register at `addr` in the bank chosen by `ch_sel` (1 = A, 0 = B).
- R7: `data_oe` is 1 exactly while `cs_n`=0 and `rd_n`=0, and 0 otherwise.
- R8: While bit 0 of the mode register (index 6) is set in either bank, a write goes to the same index in both banks, and `ch_sel` is ignored.
- R9: While broadcast is on, reads still return the bank chosen by `ch_sel`.
- R10: If the synchronized read and write strobes are both low at any time during a write strobe's low phase, that write is dropped.
- R11: Clearing bit 0 of the mode register in both banks ends broadcast, and later writes again go to a single channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Select, active low |
| ch_sel | input | 1 | Channel pick: 1 = A, 0 = B |
| addr | input | 3 | Register index inside the bank |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| data_in | input | 8 | Write data from host |
| data_out | output | 8 | Read data to host (0 when not enabled) |
| data_oe | output | 1 | Drive enable for the host data bus |

## Verification
The case that is hardest to reach from the ports is the dropped write. It needs the two strobes to overlap after synchronization, and that overlap must occur within the write strobe's low phase. The stimulus produces it in two ways. In the first, both strobes fall together and rise together. In the second, the read strobe dips for several cycles in the middle of a long write pulse. In both cases the target register is then read back to show that it still holds its earlier value. Commit timing is pinned down by starting a read a single clock after the write strobe rises, so the old value is still visible, and then showing the new value appear after the third edge.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int NUM_CH    = 2;
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int MODE_IDX  = 6;   // register holding the broadcast flag
    localparam int BCAST_BIT = 0;
    localparam int BANK_BITS = NUM_REGS * DATA_W;
    localparam int ALL_BITS  = NUM_CH * BANK_BITS;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [NUM_CH-1:0] chmask_t;

    // Channel encoding follows the select line: 1 = A, 0 = B.
    typedef enum logic {
        CH_B = 1'b0,
        CH_A = 1'b1
    } chan_e;

    // Host request as seen at the pins.
    typedef struct packed {
        logic  sel_n;
        chan_e chan;
        addr_t addr;
        data_t data;
    } bus_req_t;

    // Write command toward the banks.
    typedef struct packed {
        chmask_t we;
        addr_t   addr;
        data_t   data;
    } wr_cmd_t;

    // Banks that a write reaches.
    function automatic chmask_t chan_mask(chan_e c, logic bcast);
        chmask_t m;
        if (bcast) begin
            m = '1;
        end else begin
            m    = '0;
            m[c] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    // Idle strobes are high, so every stage resets to 1.
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '1;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/write_steer.sv
module write_steer
    import dcr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_rise,
    input  logic     wr_fall,
    input  logic     rd_sync,
    input  logic     wr_sync,
    input  bus_req_t req,
    input  logic     bcast,
    output wr_cmd_t  cmd
);

    // Marks a write cycle that saw both strobes low at once.
    logic spoiled_q;
    logic commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            spoiled_q <= 1'b0;
        end else if (wr_fall) begin
            spoiled_q <= ~rd_sync;
        end else if (~rd_sync && ~wr_sync) begin
            spoiled_q <= 1'b1;
        end
    end

    always_comb begin
        commit   = wr_rise && !spoiled_q && rd_sync && !req.sel_n;
        cmd.addr = req.addr;
        cmd.data = req.data;
        cmd.we   = commit ? chan_mask(req.chan, bcast) : '0;
    end

endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import dcr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  addr_t                waddr,
    input  data_t                wdata,
    input  addr_t                raddr,
    output data_t                rdata,
    output logic                 bcast_flag,
    output logic [BANK_BITS-1:0] contents
);

    data_t mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata      = mem[raddr];
    assign bcast_flag = mem[MODE_IDX][BCAST_BIT];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_flat
        assign contents[i*DATA_W +: DATA_W] = mem[i];
    end

endmodule

// File: rtl/dual_chan_regif.sv
module dual_chan_regif
    import dcr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ch_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    // Bit 1 carries the read strobe, bit 0 the write strobe.
    logic [1:0] strb_s;
    logic       wr_prev_q;
    logic       wr_rise;
    logic       wr_fall;

    strobe_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({rd_n, wr_n}),
        .sync_out (strb_s)
    );

    always_ff @(posedge clk) begin
        if (rst) wr_prev_q <= 1'b1;
        else     wr_prev_q <= strb_s[0];
    end

    assign wr_rise = strb_s[0] & ~wr_prev_q;
    assign wr_fall = ~strb_s[0] & wr_prev_q;

    bus_req_t req;
    wr_cmd_t  cmd;
    chmask_t  bflags;
    logic     bcast;

    assign req.sel_n = cs_n;
    assign req.chan  = chan_e'(ch_sel);
    assign req.addr  = addr;
    assign req.data  = data_in;
    assign bcast     = |bflags;

    write_steer u_steer (
        .clk     (clk),
        .rst     (rst),
        .wr_rise (wr_rise),
        .wr_fall (wr_fall),
        .rd_sync (strb_s[1]),
        .wr_sync (strb_s[0]),
        .req     (req),
        .bcast   (bcast),
        .cmd     (cmd)
    );

    data_t                rdata [NUM_CH];
    logic [ALL_BITS-1:0]  bank_flat;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
        reg_bank u_bank (
            .clk        (clk),
            .rst        (rst),
            .we         (cmd.we[c]),
            .waddr      (cmd.addr),
            .wdata      (cmd.data),
            .raddr      (addr),
            .rdata      (rdata[c]),
            .bcast_flag (bflags[c]),
            .contents   (bank_flat[c*BANK_BITS +: BANK_BITS])
        );
    end

    // Read path: pin-level and combinational, always follows ch_sel.
    assign data_oe  = ~cs_n & ~rd_n;
    assign data_out = data_oe ? rdata[ch_sel] : '0;

endmodule

// File: rtl/dual_chan_regif_chk.sv
module dual_chan_regif_chk
    import dcr_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                cs_n,
    input logic                data_oe,
    input logic                rd_sync,
    input logic                wr_sync,
    input logic [NUM_CH-1:0]   ch_we,
    input logic                bcast,
    input logic [ALL_BITS-1:0] bank_flat
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bank_flat == '0));

    p_release_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !data_oe);

    p_single_chan_r3: assert property (@(posedge clk) disable iff (rst)
        !bcast |-> $onehot0(ch_we));

    p_no_commit_r5: assert property (@(posedge clk) disable iff (rst)
        (ch_we == '0) |=> $stable(bank_flat));

    p_both_banks_r8: assert property (@(posedge clk) disable iff (rst)
        (bcast && (ch_we != '0)) |-> (&ch_we));

    p_collide_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!rd_sync && !wr_sync) |=> $stable(bank_flat));

endmodule

bind dual_chan_regif dual_chan_regif_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .data_oe   (data_oe),
    .rd_sync   (strb_s[1]),
    .wr_sync   (strb_s[0]),
    .ch_we     (cmd.we),
    .bcast     (bcast),
    .bank_flat (bank_flat)
);

// File: tb/dual_chan_regif_tb_top.sv
`timescale 1ns/1ps
module dual_chan_regif_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       ch_sel = 1'b0;
    logic [2:0] addr = '0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model [2][8];   // [ch_sel value][index]

    always #4 clk = ~clk;   // 125 MHz

    dual_chan_regif dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ch_sel(ch_sel), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic raw_write(logic sel, logic ch, logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        cs_n = sel; ch_sel = ch; addr = a; data_in = d; wr_n = 1'b0;
        wait_n(4);
        wr_n = 1'b1;
        wait_n(5);
        cs_n = 1'b1;
    endtask

    // Selected write; model follows R3/R8.
    task automatic do_write(logic ch, logic [2:0] a, logic [7:0] d);
        logic bc;
        bc = model[0][6][0] | model[1][6][0];
        if (bc) begin
            model[0][a] = d;
            model[1][a] = d;
        end else begin
            model[ch][a] = d;
        end
        raw_write(1'b0, ch, a, d);
    endtask

    task automatic do_read(logic ch, logic [2:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; ch_sel = ch; addr = a; rd_n = 1'b0;
        #1;
        d = data_out; oe = data_oe;
        rd_n = 1'b1; cs_n = 1'b1;
        wait_n(4);
    endtask

    task automatic check_reg(string req, logic ch, logic [2:0] a);
        logic [7:0] d;
        logic oe;
        do_read(ch, a, d, oe);
        check(req, d, model[ch][a]);
    endtask

    task automatic check_all(string req);
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 8; a++)
                check_reg(req, c[0], a[2:0]);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        wait_n(4);
        rst = 1'b0;
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 8; a++)
                model[c][a] = 8'h00;
        wait_n(2);
        check_all("R1 reset clear");
        // broadcast off: write to A leaves B untouched
        do_write(1'b1, 3'd1, 8'hA1);
        check_reg("R1 broadcast off", 1'b0, 3'd1);
    endtask

    task automatic t_steer;
        do_write(1'b1, 3'd0, 8'h10);
        do_write(1'b0, 3'd0, 8'h20);
        do_write(1'b1, 3'd7, 8'h7A);
        do_write(1'b0, 3'd5, 8'h5B);
        check_reg("R3 chan A", 1'b1, 3'd0);
        check_reg("R3 chan B", 1'b0, 3'd0);
        check_reg("R3 B untouched by A write", 1'b0, 3'd7);
        check_all("R4 other indices intact");
    endtask

    task automatic t_cs_ignore;
        logic [7:0] d;
        logic oe;
        raw_write(1'b1, 1'b1, 3'd0, 8'hEE);
        check_reg("R2 deselected write ignored", 1'b1, 3'd0);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; addr = 3'd0;
        #1; check("R2 oe low when deselected", {7'd0, data_oe}, 8'd0);
        rd_n = 1'b1;
        wait_n(4);
        do_read(1'b1, 3'd0, d, oe);
        check("R7 oe high on read", {7'd0, oe}, 8'd1);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b1;
        #1; check("R7 oe low without read strobe", {7'd0, data_oe}, 8'd0);
        cs_n = 1'b1;
    endtask

    task automatic t_commit;
        logic [7:0] d;
        @(negedge clk);
        cs_n = 1'b0; ch_sel = 1'b1; addr = 3'd2; data_in = 8'hC3; wr_n = 1'b0;
        wait_n(4);
        wr_n = 1'b1;
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);   // two edges after rise
        #1; d = data_out;
        check("R5 old value before commit", d, model[1][2]);
        @(negedge clk);   // third edge
        #1; d = data_out;
        model[1][2] = 8'hC3;
        check("R5 new value after commit", d, 8'hC3);
        check("R6 read path matches", d, model[1][2]);
        rd_n = 1'b1;
        wait_n(4);
        cs_n = 1'b1;
        wait_n(2);
    endtask

    task automatic t_broadcast;
        logic [7:0] d;
        logic oe;
        do_write(1'b1, 3'd4, 8'h11);
        do_write(1'b0, 3'd4, 8'h22);
        do_write(1'b1, 3'd6, 8'h01);          // broadcast on via A
        do_write(1'b0, 3'd3, 8'h5A);
        check_reg("R8 bcast reaches A", 1'b1, 3'd3);
        check_reg("R8 bcast reaches B", 1'b0, 3'd3);
        do_read(1'b1, 3'd4, d, oe);
        check("R9 read A during bcast", d, 8'h11);
        do_read(1'b0, 3'd4, d, oe);
        check("R9 read B during bcast", d, 8'h22);
        do_write(1'b1, 3'd6, 8'h00);          // clears both mode regs
        check_reg("R11 mode cleared in B", 1'b0, 3'd6);
        do_write(1'b1, 3'd3, 8'h77);
        check_reg("R11 single write to A", 1'b1, 3'd3);
        check_reg("R11 B keeps old", 1'b0, 3'd3);
        do_write(1'b0, 3'd6, 8'h01);          // broadcast on via B
        do_write(1'b1, 3'd5, 8'h3C);
        check_reg("R8 bcast via B flag", 1'b0, 3'd5);
        do_write(1'b0, 3'd6, 8'h00);
        check_all("R8 full map after bcast");
    endtask

    task automatic t_collision;
        @(negedge clk);
        cs_n = 1'b0; ch_sel = 1'b1; addr = 3'd0; data_in = 8'h99;
        rd_n = 1'b0; wr_n = 1'b0;
        wait_n(5);
        rd_n = 1'b1; wr_n = 1'b1;
        wait_n(6);
        cs_n = 1'b1;
        check_reg("R10 joint strobes dropped", 1'b1, 3'd0);
        @(negedge clk);
        cs_n = 1'b0; ch_sel = 1'b0; addr = 3'd0; data_in = 8'h66; wr_n = 1'b0;
        wait_n(4);
        rd_n = 1'b0;
        wait_n(4);
        rd_n = 1'b1;
        wait_n(4);
        wr_n = 1'b1;
        wait_n(6);
        cs_n = 1'b1;
        check_reg("R10 read dip dropped", 1'b0, 3'd0);
        do_write(1'b0, 3'd0, 8'h42);
        check_reg("R10 next write works", 1'b0, 3'd0);
    endtask

    initial begin
        t_reset();
        t_steer();
        t_cs_ignore();
        t_commit();
        t_broadcast();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule